// File: doc/BRIEF.md
# Single-Precision Floating-Point Multiplier

This block multiplies two 32-bit binary floating-point words (1 sign bit, 8-bit biased exponent, 23-bit fraction, bias 127) and returns their rounded product. An operation is issued by raising `in_valid` for one cycle with both operands present. Operations may arrive back to back, and each one produces exactly one `out_valid` pulse two clock cycles later.

The datapath decodes each operand into a class (zero, subnormal, normal, infinity or NaN) and restores the hidden significand bit. It forms the 48-bit significand product and sums the exponents with a single bias correction. A leading-zero count places the product in [1.0, 2.0). Results below the normal range are shifted into subnormal form. The value is then rounded to nearest with ties to even, and renormalised when the rounding increment carries out. Products that are too large saturate to a signed infinity. The flags `flag_ovf`, `flag_unf` and `flag_inv` accompany each result.

Top module: `fp32_mul`

## Requirements
- R1: Each cycle with `in_valid` high yields exactly one `out_valid` pulse two rising edges later. With no issue, `out_valid` stays low.
- R2: For every result that is not a NaN, the sign bit equals the XOR of the two operand sign bits.
- R3: For finite nonzero operands, the result is the exact product rounded to nearest, ties to even. The result exponent field is the sum of the operand exponent fields minus 127, corrected by the normalisation shift.
- R4: When rounding carries out of the 24-bit significand, the significand is shifted right one place and the exponent rises by one. Example: 0x3FFFFFFE × 0x3F800001 gives 0x40000000.
- R5: If the rounded exponent field reaches 255, the result is infinity with the product's sign (exponent field 0xFF, fraction 0) and `flag_ovf` is set. 0x7F000000 × 0x3F800000 stays 0x7F000000 with no flag.
- R6: If the biased exponent of the normalised product, before rounding, is below 1, the result is rounded at the subnormal quantum 2^-149 and may become zero or the smallest normal. `flag_unf` is set when that result is inexact; an exact subnormal leaves it clear.
- R7: An operand whose exponent field is 0 with a nonzero fraction is taken as 0.fraction × 2^-126.
- R8: If either operand is a NaN (exponent field 0xFF, nonzero fraction), the result is 0x7FC00000. `flag_inv` stays clear, even when the other operand is zero.
- R9: Infinity times zero, in either order and with either signs, gives 0x7FC00000 with `flag_inv` set.
- R10: Infinity times a nonzero non-NaN value gives a signed infinity. Zero times a finite value gives a signed zero. Both raise no flag.
- R11: At most one flag is high at a time, and all flags are low in any cycle in which `out_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| in_valid | input | 1 | Issues one multiplication this cycle |
| op_a | input | 32 | First operand |
| op_b | input | 32 | Second operand |
| out_valid | output | 1 | Result and flags are valid |
| result | output | 32 | Rounded product |
| flag_ovf | output | 1 | Result overflowed to infinity |
| flag_unf | output | 1 | Result is tiny and inexact |
| flag_inv | output | 1 | Invalid operation (infinity times zero) |

## Verification
The sharpest coincidence is a rounding carry-out in the same cycle as a range boundary. 0x7F7FFFFE × 0x3F800001 is just below the top of the range until the increment carries it into exponent 255, so it must report overflow. 0x007FFFFF × 0x3F800001 is tiny before rounding and is promoted by the carry to 0x00800000, so it must still raise the underflow flag. A behavioural model in the bench works from integer products and explicit rounding-point arithmetic, so it finds both outcomes without sharing the design's structure. These and many pseudo-random operand pairs are compared against the outputs every cycle.

// File: rtl/fpm_pkg.sv
package fpm_pkg;
  localparam int EXP_W   = 8;
  localparam int FRAC_W  = 23;
  localparam int SIG_W   = FRAC_W + 1;
  localparam int PROD_W  = 2 * SIG_W;
  localparam int WORD_W  = 1 + EXP_W + FRAC_W;
  localparam int BIAS    = (1 << (EXP_W - 1)) - 1;
  localparam int EXP_MAX = (1 << EXP_W) - 1;
  localparam int XE_W    = EXP_W + 2;
  localparam int LZ_W    = $clog2(PROD_W + 2);

  localparam logic [WORD_W-1:0] QNAN_WORD =
    {1'b0, {EXP_W{1'b1}}, 1'b1, {(FRAC_W-1){1'b0}}};

  typedef struct packed {
    logic              sign;
    logic              zero;
    logic              inf;
    logic              nan;
    logic [EXP_W-1:0]  exp;
    logic [SIG_W-1:0]  sig;
  } fpm_opnd_t;
endpackage

// File: rtl/fpm_unpack.sv
module fpm_unpack
  import fpm_pkg::*;
(
  input  logic [WORD_W-1:0] word,
  output fpm_opnd_t         opnd
);
  logic [EXP_W-1:0]  exp_f;
  logic [FRAC_W-1:0] frac_f;
  logic              exp_lo;
  logic              exp_hi;
  logic              frac_nz;

  always_comb begin
    exp_f   = word[WORD_W-2:FRAC_W];
    frac_f  = word[FRAC_W-1:0];
    exp_lo  = (exp_f == '0);
    exp_hi  = (exp_f == '1);
    frac_nz = |frac_f;
    opnd.sign = word[WORD_W-1];
    opnd.zero = exp_lo & ~frac_nz;
    opnd.inf  = exp_hi & ~frac_nz;
    opnd.nan  = exp_hi & frac_nz;
    opnd.exp  = exp_lo ? EXP_W'(1) : exp_f;
    opnd.sig  = {~exp_lo, frac_f};
  end
endmodule

// File: rtl/fpm_lzc.sv
module fpm_lzc #(
  parameter int W  = 48,
  parameter int CW = $clog2(W + 1)
) (
  input  logic [W-1:0]  vec,
  output logic [CW-1:0] count
);
  always_comb begin
    logic found;
    found = 1'b0;
    count = CW'(W);
    for (int i = W - 1; i >= 0; i--) begin
      if (!found && vec[i]) begin
        count = CW'(W - 1 - i);
        found = 1'b1;
      end
    end
  end
endmodule

// File: rtl/fpm_round.sv
module fpm_round
  import fpm_pkg::*;
(
  input  logic                    sign,
  input  logic signed [XE_W-1:0]  xexp,
  input  logic [PROD_W-1:0]       prod,
  output logic [WORD_W-1:0]       word,
  output logic                    ovf,
  output logic                    unf
);
  localparam int SHW = PROD_W + 1;
  localparam logic signed [XE_W-1:0] SH_CAP  = XE_W'(SHW);
  localparam logic signed [XE_W-1:0] EXP_TOP = XE_W'(EXP_MAX);
  localparam logic signed [XE_W-1:0] ONE_S   = XE_W'(1);

  logic [LZ_W-1:0]          lz;
  logic [PROD_W-1:0]        norm;
  logic signed [XE_W-1:0]   e_norm;
  logic signed [XE_W-1:0]   sh_raw;
  logic signed [XE_W-1:0]   e_base;
  logic signed [XE_W-1:0]   e_fin;
  logic [LZ_W-1:0]          sh;
  logic [PROD_W+SHW-1:0]    wide;
  logic [PROD_W-1:0]        kept;
  logic [SIG_W-1:0]         mant;
  logic [SIG_W:0]           sum;
  logic [SIG_W-1:0]         sig_out;
  logic                     tiny, g_bit, r_bit, s_bit, inexact, up;

  fpm_lzc #(.W(PROD_W), .CW(LZ_W)) u_lzc (
    .vec   (prod),
    .count (lz)
  );

  always_comb begin
    norm   = prod << lz;
    e_norm = xexp + ONE_S - $signed({{(XE_W-LZ_W){1'b0}}, lz});
    tiny   = (e_norm <= 0);
    sh_raw = ONE_S - e_norm;
    if (!tiny)               sh = '0;
    else if (sh_raw > SH_CAP) sh = SH_CAP[LZ_W-1:0];
    else                      sh = sh_raw[LZ_W-1:0];

    wide    = {norm, {SHW{1'b0}}} >> sh;
    kept    = wide[PROD_W+SHW-1:SHW];
    mant    = kept[PROD_W-1:PROD_W-SIG_W];
    g_bit   = kept[PROD_W-SIG_W-1];
    r_bit   = kept[PROD_W-SIG_W-2];
    s_bit   = (|kept[PROD_W-SIG_W-3:0]) | (|wide[SHW-1:0]);
    inexact = g_bit | r_bit | s_bit;
    up      = g_bit & (r_bit | s_bit | mant[0]);
    sum     = {1'b0, mant} + {{SIG_W{1'b0}}, up};

    e_base = tiny ? '0 : e_norm;
    if (sum[SIG_W]) begin
      sig_out = sum[SIG_W:1];
      e_fin   = e_base + ONE_S;
    end else if (tiny && sum[SIG_W-1]) begin
      sig_out = sum[SIG_W-1:0];
      e_fin   = ONE_S;
    end else begin
      sig_out = sum[SIG_W-1:0];
      e_fin   = e_base;
    end

    ovf = (e_fin >= EXP_TOP);
    unf = tiny & inexact;
    if (ovf) word = {sign, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else     word = {sign, e_fin[EXP_W-1:0], sig_out[FRAC_W-1:0]};
  end
endmodule

// File: rtl/fp32_mul.sv
module fp32_mul
  import fpm_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        in_valid,
  input  logic [31:0] op_a,
  input  logic [31:0] op_b,
  output logic        out_valid,
  output logic [31:0] result,
  output logic        flag_ovf,
  output logic        flag_unf,
  output logic        flag_inv
);
  localparam int NOPS = 2;

  logic [WORD_W-1:0] words [NOPS];
  fpm_opnd_t         opd   [NOPS];

  assign words[0] = op_a;
  assign words[1] = op_b;

  for (genvar gi = 0; gi < NOPS; gi++) begin : g_unpack
    fpm_unpack u_unpack (
      .word (words[gi]),
      .opnd (opd[gi])
    );
  end

  // stage 1 next-state
  logic                   sgn_nx, nan_nx, inv_nx, inf_nx, zero_nx, sp_nx;
  logic [WORD_W-1:0]      sp_word_nx;
  logic signed [XE_W-1:0] xexp_nx;
  logic [PROD_W-1:0]      prod_nx;

  always_comb begin
    sgn_nx  = opd[0].sign ^ opd[1].sign;
    nan_nx  = opd[0].nan | opd[1].nan;
    inv_nx  = ~nan_nx & ((opd[0].inf & opd[1].zero) | (opd[0].zero & opd[1].inf));
    inf_nx  = opd[0].inf | opd[1].inf;
    zero_nx = opd[0].zero | opd[1].zero;
    sp_nx   = nan_nx | inf_nx | zero_nx;
    if (nan_nx || inv_nx) sp_word_nx = QNAN_WORD;
    else if (inf_nx)      sp_word_nx = {sgn_nx, {EXP_W{1'b1}}, {FRAC_W{1'b0}}};
    else                  sp_word_nx = {sgn_nx, {(WORD_W-1){1'b0}}};
    xexp_nx = $signed({{(XE_W-EXP_W){1'b0}}, opd[0].exp})
            + $signed({{(XE_W-EXP_W){1'b0}}, opd[1].exp})
            - $signed(XE_W'(BIAS));
    prod_nx = opd[0].sig * opd[1].sig;
  end

  // stage 1 registers
  logic                   s1_valid, s1_sp, s1_inv, s1_sign;
  logic [WORD_W-1:0]      s1_sp_word;
  logic signed [XE_W-1:0] s1_xexp;
  logic [PROD_W-1:0]      s1_prod;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) s1_valid <= 1'b0;
    else        s1_valid <= in_valid;
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      s1_sp      <= sp_nx;
      s1_inv     <= inv_nx;
      s1_sign    <= sgn_nx;
      s1_sp_word <= sp_word_nx;
      s1_xexp    <= xexp_nx;
      s1_prod    <= prod_nx;
    end
  end

  // stage 2: normalise, round, pack
  logic [WORD_W-1:0] rnd_word;
  logic              rnd_ovf, rnd_unf;

  fpm_round u_round (
    .sign (s1_sign),
    .xexp (s1_xexp),
    .prod (s1_prod),
    .word (rnd_word),
    .ovf  (rnd_ovf),
    .unf  (rnd_unf)
  );

  logic [WORD_W-1:0] res_nx;
  logic              ovf_nx, unf_nx, invf_nx;

  always_comb begin
    res_nx  = s1_sp ? s1_sp_word : rnd_word;
    ovf_nx  = s1_valid & ~s1_sp & rnd_ovf;
    unf_nx  = s1_valid & ~s1_sp & rnd_unf;
    invf_nx = s1_valid & s1_sp & s1_inv;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      flag_ovf  <= 1'b0;
      flag_unf  <= 1'b0;
      flag_inv  <= 1'b0;
    end else begin
      out_valid <= s1_valid;
      flag_ovf  <= ovf_nx;
      flag_unf  <= unf_nx;
      flag_inv  <= invf_nx;
    end
  end

  always_ff @(posedge clk) begin
    if (s1_valid) result <= res_nx;
  end
endmodule

// File: rtl/fp32_mul_chk.sv
module fp32_mul_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        in_valid,
  input logic        a_sign,
  input logic        b_sign,
  input logic        out_valid,
  input logic [31:0] result,
  input logic        flag_ovf,
  input logic        flag_unf,
  input logic        flag_inv
);
  logic [1:0] since_rst;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               since_rst <= '0;
    else if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
  end
  logic warm;
  assign warm = (since_rst >= 2'd2);

  a_r1_issue_to_result: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> ##1 out_valid);
  a_r1_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid) |-> $past(in_valid, 2));
  a_r2_sign_xor: assert property (@(posedge clk) disable iff (!rst_n)
    (warm && out_valid && result[30:22] != 9'h1FF) |-> result[31] == $past(a_sign ^ b_sign, 2));
  a_r5_ovf_is_inf: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_ovf) |-> result[30:0] == 31'h7F800000);
  a_r6_unf_small: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_unf) |-> result[30:23] <= 8'd1);
  a_r9_inv_qnan: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && flag_inv) |-> result == 32'h7FC00000);
  a_r11_flags_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(flag_ovf || flag_unf || flag_inv));
  a_r11_one_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flag_ovf, flag_unf, flag_inv}));
endmodule

bind fp32_mul fp32_mul_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .a_sign    (op_a[31]),
  .b_sign    (op_b[31]),
  .out_valid (out_valid),
  .result    (result),
  .flag_ovf  (flag_ovf),
  .flag_unf  (flag_unf),
  .flag_inv  (flag_inv)
);

// File: tb/fp32_mul_bench.sv
module fp32_mul_bench;
  logic        clk;
  logic        rst_n;
  logic        in_valid;
  logic [31:0] op_a, op_b;
  logic        out_valid;
  logic [31:0] result;
  logic        flag_ovf, flag_unf, flag_inv;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  fp32_mul u_fp32_mul (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
    .out_valid(out_valid), .result(result),
    .flag_ovf(flag_ovf), .flag_unf(flag_unf), .flag_inv(flag_inv)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // expected-value pipeline: slot 0 issued last cycle, slot 1 due now
  logic        pv [2];
  logic [31:0] pr [2];
  logic        po [2], pu [2], pi [2];
  string       pt [2];

  function automatic void ref_mul(input logic [31:0] a, input logic [31:0] b,
                                  output logic [31:0] r, output logic ovf,
                                  output logic unf, output logic inv);
    int ea, eb, k, p, drop, e;
    longint unsigned ma, mb, prod, q, rem, half;
    logic s, an, bn, ai, bi, az, bz, inexact, tiny, up;
    s  = a[31] ^ b[31];
    ea = int'(a[30:23]); eb = int'(b[30:23]);
    an = (ea == 255) && (a[22:0] != 0); bn = (eb == 255) && (b[22:0] != 0);
    ai = (ea == 255) && (a[22:0] == 0); bi = (eb == 255) && (b[22:0] == 0);
    az = (ea == 0) && (a[22:0] == 0);   bz = (eb == 0) && (b[22:0] == 0);
    ovf = 0; unf = 0; inv = 0;
    if (an || bn) begin r = 32'h7FC00000; return; end
    if ((ai && bz) || (az && bi)) begin r = 32'h7FC00000; inv = 1; return; end
    if (ai || bi) begin r = {s, 8'hFF, 23'd0}; return; end
    if (az || bz) begin r = {s, 31'd0}; return; end
    ma = {41'd0, a[22:0]}; mb = {41'd0, b[22:0]};
    if (ea == 0) ea = 1; else ma = ma + 64'h800000;
    if (eb == 0) eb = 1; else mb = mb + 64'h800000;
    prod = ma * mb;
    k = ea + eb - 254 - 46;
    p = 0;
    for (int i = 0; i < 48; i++) if (prod[i]) p = i;
    tiny = (p + k + 127) < 1;
    drop = p - 23;
    if (-149 - k > drop) drop = -149 - k;
    if (drop <= 0) begin
      q = prod << (-drop); inexact = 0; up = 0;
    end else if (drop >= 50) begin
      q = 0; inexact = 1; up = 0;
    end else begin
      q    = prod >> drop;
      rem  = prod & ((64'd1 << drop) - 1);
      half = 64'd1 << (drop - 1);
      up   = (rem > half) || (rem == half && q[0]);
      inexact = (rem != 0);
    end
    q = q + (up ? 64'd1 : 64'd0);
    if (q == 64'h1000000) begin q = q >> 1; drop = drop + 1; end
    unf = tiny && inexact;
    if (q < 64'h800000) r = {s, 8'd0, q[22:0]};
    else begin
      e = drop + k + 150;
      if (e >= 255) begin r = {s, 8'hFF, 23'd0}; ovf = 1; end
      else r = {s, e[7:0], q[22:0]};
    end
  endfunction

  task automatic compare_due();
    logic bad;
    checks++;
    bad = (out_valid !== pv[1]);
    if (pv[1]) bad = bad || (result !== pr[1]) || (flag_ovf !== po[1])
                     || (flag_unf !== pu[1]) || (flag_inv !== pi[1]);
    else       bad = bad || (flag_ovf !== 1'b0) || (flag_unf !== 1'b0) || (flag_inv !== 1'b0);
    if (bad) begin
      errors++;
      $display("FAIL %s: got v=%0b r=%08h o/u/i=%0b%0b%0b, expected v=%0b r=%08h o/u/i=%0b%0b%0b",
               pt[1], out_valid, result, flag_ovf, flag_unf, flag_inv,
               pv[1], pr[1], po[1], pu[1], pi[1]);
    end
  endtask

  task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b, input string tag);
    logic [31:0] r; logic o, u, i;
    @(negedge clk);
    compare_due();
    pv[1] = pv[0]; pr[1] = pr[0]; po[1] = po[0]; pu[1] = pu[0]; pi[1] = pi[0]; pt[1] = pt[0];
    ref_mul(a, b, r, o, u, i);
    pv[0] = v; pr[0] = r; po[0] = o; pu[0] = u; pi[0] = i;
    pt[0] = v ? tag : "R1 idle";
    in_valid = v; op_a = a; op_b = b;
  endtask

  initial begin
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] x;
    rst_n = 1'b0; in_valid = 1'b0; op_a = '0; op_b = '0;
    for (int j = 0; j < 2; j++) begin
      pv[j] = 0; pr[j] = '0; po[j] = 0; pu[j] = 0; pi[j] = 0; pt[j] = "R1 idle";
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (out_valid !== 1'b0 || flag_ovf !== 1'b0 || flag_unf !== 1'b0 || flag_inv !== 1'b0) begin
      errors++;
      $display("FAIL R1 reset state: got v=%0b flags=%0b%0b%0b, expected 0 and 000",
               out_valid, flag_ovf, flag_unf, flag_inv);
    end
    rst_n = 1'b1;
    step(0, 0, 0, "R1");
    step(1, 32'h3FC00000, 32'h40000000, "R3 1.5x2");
    step(1, 32'hC0000000, 32'h40400000, "R2 neg sign");
    step(0, 0, 0, "R1");
    step(1, 32'h3F800001, 32'h3F800001, "R3 rounding");
    step(1, 32'h3FFFFFFE, 32'h3F800001, "R4 carry out");
    step(1, 32'h7EFFFFFE, 32'h3F800001, "R4 carry to top");
    step(1, 32'h7F7FFFFE, 32'h3F800001, "R5 carry into overflow");
    step(1, 32'h7F000000, 32'h40000000, "R5 overflow");
    step(1, 32'hFF000000, 32'h40400000, "R5 neg overflow");
    step(1, 32'h7F000000, 32'h3F800000, "R5 boundary");
    step(1, 32'h00800000, 32'h3F000000, "R6 exact subnormal");
    step(1, 32'h00800001, 32'h3F000000, "R6 inexact subnormal");
    step(1, 32'h00800000, 32'h00800000, "R6 flush");
    step(1, 32'h80800000, 32'h00800000, "R6 neg flush");
    step(1, 32'h007FFFFF, 32'h3F800001, "R6 promote to normal");
    step(1, 32'h00000001, 32'h4B000000, "R7 min subnormal");
    step(1, 32'h00400000, 32'h40000000, "R7 subnormal x2");
    step(1, 32'h00000003, 32'h3F000000, "R7 tie to even");
    step(1, 32'h7FC00001, 32'h3F800000, "R8 nan");
    step(1, 32'hFF800001, 32'h00000000, "R8 nan x zero");
    step(1, 32'h7F800000, 32'h00000000, "R9 inf x zero");
    step(1, 32'h80000000, 32'hFF800000, "R9 zero x inf");
    step(1, 32'h7F800000, 32'hC0000000, "R10 inf x neg");
    step(1, 32'h00000000, 32'hC0A00000, "R10 zero x neg");
    step(1, 32'hFF800000, 32'h00000001, "R10 inf x subnormal");
    step(0, 0, 0, "R11");
    step(0, 0, 0, "R11");
    x = 32'h1234ABCD;
    for (int n = 0; n < 400; n++) begin
      logic [31:0] a, b;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5; a = x;
      x ^= x << 13; x ^= x >> 17; x ^= x << 5; b = x;
      if (n % 3 == 0) b = {b[31], 2'b01, b[28:0]};
      step(n % 7 != 6, a, b, "R3 random");
    end
    repeat (3) step(0, 0, 0, "R1 drain");
    done = 1;
    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule